// File: doc/BRIEF.md
# Companding Line Character Coder

This block sits between the sign/segment/step output of a voice converter and the serial PCM shifter. In the transmit direction it turns an internal code (a sign bit, a segment number and a step number, where segment 0 step 0 is the smallest magnitude) into the 8-bit character that goes on the line. In the receive direction it turns a line character back into the internal code. The two directions are exact inverses over all 256 characters.

A select input chooses between two line conventions. In the first, which is for mu-law, every magnitude bit is inverted. In the second, which is for A-law, only the even-numbered bits of the character are inverted, which is an exclusive-OR with 0x55. In both conventions the most significant bit is the sign and is sent unchanged, with 1 meaning positive. A parameter can fix the convention at build time instead. Another parameter chooses between a purely combinational path and a one-cycle registered stage with a valid flag.

Top module: `pcm_law_coder`

## Requirements
- R1: When law_sel = 0 (mu-law) and the stage is registered, an accepted transmit word produces enc_char = {enc_sign, ~{enc_seg, enc_step}}. The character's bit 7 is the sign, bits 6:4 carry the segment and bits 3:0 carry the step.
- R2: When law_sel = 1 (A-law), an accepted transmit word produces enc_char = {enc_sign, {enc_seg, enc_step} ^ 7'h55}. Bit 7 is never inverted.
- R3: In mu-law, the four end points encode as follows. Positive full scale (sign 1, seg 7, step 15) gives 8'h80. Negative full scale gives 8'h00. Positive zero (sign 1, seg 0, step 0) gives 8'hFF. Negative zero gives 8'h7F.
- R4: In A-law, the same four end points encode as 8'hAA, 8'h2A, 8'hD5 and 8'h55 respectively.
- R5: Decoding any of the 256 characters under either law, then encoding the decoded code under the same law, returns the original character.
- R6: Each valid output rises exactly one clock after its valid input is sampled high. It is low in the cycle after its valid input is sampled low.
- R7: While a valid input is low, the matching data output holds its previous value, whatever the data inputs do.
- R8: While rst_n is low, both valid outputs and all data outputs are 0.
- R9: The decoded sign, dec_sign, equals bit 7 of the accepted received character, under both laws.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| law_sel | input | 1 | Line convention: 0 selects mu-law, 1 selects A-law |
| enc_valid_in | input | 1 | Transmit word present |
| enc_sign | input | 1 | Transmit sign, 1 = positive |
| enc_seg | input | 3 | Transmit segment |
| enc_step | input | 4 | Transmit step within the segment |
| enc_valid_out | output | 1 | Transmit character valid |
| enc_char | output | 8 | Line character to send |
| dec_valid_in | input | 1 | Received character present |
| dec_char | input | 8 | Received line character |
| dec_valid_out | output | 1 | Decoded code valid |
| dec_sign | output | 1 | Decoded sign, 1 = positive |
| dec_seg | output | 3 | Decoded segment |
| dec_step | output | 4 | Decoded step |

## Verification
With the default registered stage, every transmit and receive result is due on the clock edge after the one that samples its valid input. The bench therefore drives inputs on the falling edge. On the next falling edge it compares the outputs with a queue-free model whose expected values were updated when those inputs were driven. The round-trip sweep feeds the decoded outputs back into the encoder and so expects each original character two cycles after it was driven. The hold and reset checks compare the outputs on every cycle in which no valid input was sampled.

// File: rtl/lawcoder_pkg.sv
package lawcoder_pkg;

   typedef enum logic {
      LAW_MU = 1'b0,
      LAW_A  = 1'b1
   } law_e;

   // Mask that has every even-numbered bit set; the A-law line convention uses it
   function automatic logic [31:0] even_bits_mask();
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 32; i += 2) m[i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/lc_encode.sv
module lc_encode
   import lawcoder_pkg::*;
#(
   parameter int SEG_W  = 3,
   parameter int STEP_W = 4,
   localparam int MAG_W  = SEG_W + STEP_W,
   localparam int CHAR_W = MAG_W + 1
) (
   input  law_e               law,
   input  logic               sign,
   input  logic [SEG_W-1:0]   seg,
   input  logic [STEP_W-1:0]  step,
   output logic [CHAR_W-1:0]  line_char
);
   localparam logic [31:0]      EVEN_ALL = even_bits_mask();
   localparam logic [MAG_W-1:0] MASK_A   = EVEN_ALL[MAG_W-1:0];
   localparam logic [MAG_W-1:0] MASK_MU  = '1;

   logic [MAG_W-1:0] mag;
   logic [MAG_W-1:0] mask;

   assign mag       = {seg, step};
   assign mask      = (law == LAW_A) ? MASK_A : MASK_MU;
   assign line_char = {sign, mag ^ mask};
endmodule

// File: rtl/lc_decode.sv
module lc_decode
   import lawcoder_pkg::*;
#(
   parameter int SEG_W  = 3,
   parameter int STEP_W = 4,
   localparam int MAG_W  = SEG_W + STEP_W,
   localparam int CHAR_W = MAG_W + 1
) (
   input  law_e               law,
   input  logic [CHAR_W-1:0]  line_char,
   output logic               sign,
   output logic [SEG_W-1:0]   seg,
   output logic [STEP_W-1:0]  step
);
   localparam logic [31:0]      EVEN_ALL = even_bits_mask();
   localparam logic [MAG_W-1:0] MASK_A   = EVEN_ALL[MAG_W-1:0];
   localparam logic [MAG_W-1:0] MASK_MU  = '1;

   logic [MAG_W-1:0] mag;

   assign mag  = line_char[MAG_W-1:0] ^ ((law == LAW_A) ? MASK_A : MASK_MU);
   assign sign = line_char[CHAR_W-1];
   assign seg  = mag[MAG_W-1:STEP_W];
   assign step = mag[STEP_W-1:0];
endmodule

// File: rtl/lc_stage.sv
module lc_stage #(
   parameter int W       = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vin,
   input  logic [W-1:0]  din,
   output logic          vout,
   output logic [W-1:0]  dout
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vout <= 1'b0;
               dout <= '0;
            end else begin
               vout <= vin;
               if (vin) dout <= din;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign vout = vin;
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/pcm_law_coder.sv
module pcm_law_coder
   import lawcoder_pkg::*;
#(
   parameter int SEG_W     = 3,
   parameter int STEP_W    = 4,
   parameter bit OUT_REG   = 1'b1,
   parameter int FORCE_LAW = 0,       // 0: follow law_sel, 1: mu-law, 2: A-law
   localparam int MAG_W  = SEG_W + STEP_W,
   localparam int CHAR_W = MAG_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               law_sel,
   input  logic               enc_valid_in,
   input  logic               enc_sign,
   input  logic [SEG_W-1:0]   enc_seg,
   input  logic [STEP_W-1:0]  enc_step,
   output logic               enc_valid_out,
   output logic [CHAR_W-1:0]  enc_char,
   input  logic               dec_valid_in,
   input  logic [CHAR_W-1:0]  dec_char,
   output logic               dec_valid_out,
   output logic               dec_sign,
   output logic [SEG_W-1:0]   dec_seg,
   output logic [STEP_W-1:0]  dec_step
);
   generate
      if (SEG_W < 1 || STEP_W < 1) begin : g_bad_width
         $error("pcm_law_coder: SEG_W and STEP_W must be at least 1");
      end
      if (MAG_W > 31) begin : g_bad_mag
         $error("pcm_law_coder: magnitude wider than the mask function");
      end
      if (FORCE_LAW < 0 || FORCE_LAW > 2) begin : g_bad_force
         $error("pcm_law_coder: FORCE_LAW must be 0, 1 or 2");
      end
   endgenerate

   law_e law_eff;
   generate
      if (FORCE_LAW == 1) begin : g_fix_mu
         assign law_eff = LAW_MU;
      end else if (FORCE_LAW == 2) begin : g_fix_a
         assign law_eff = LAW_A;
      end else begin : g_runtime
         assign law_eff = law_e'(law_sel);
      end
   endgenerate

   logic [CHAR_W-1:0] enc_raw;
   logic              dec_raw_sign;
   logic [SEG_W-1:0]  dec_raw_seg;
   logic [STEP_W-1:0] dec_raw_step;
   logic [CHAR_W-1:0] dec_bus;

   lc_encode #(.SEG_W(SEG_W), .STEP_W(STEP_W)) u_enc (
      .law       (law_eff),
      .sign      (enc_sign),
      .seg       (enc_seg),
      .step      (enc_step),
      .line_char (enc_raw)
   );

   lc_decode #(.SEG_W(SEG_W), .STEP_W(STEP_W)) u_dec (
      .law       (law_eff),
      .line_char (dec_char),
      .sign      (dec_raw_sign),
      .seg       (dec_raw_seg),
      .step      (dec_raw_step)
   );

   lc_stage #(.W(CHAR_W), .OUT_REG(OUT_REG)) u_enc_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .vin   (enc_valid_in),
      .din   (enc_raw),
      .vout  (enc_valid_out),
      .dout  (enc_char)
   );

   lc_stage #(.W(CHAR_W), .OUT_REG(OUT_REG)) u_dec_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .vin   (dec_valid_in),
      .din   ({dec_raw_sign, dec_raw_seg, dec_raw_step}),
      .vout  (dec_valid_out),
      .dout  (dec_bus)
   );

   assign dec_sign = dec_bus[CHAR_W-1];
   assign dec_seg  = dec_bus[MAG_W-1:STEP_W];
   assign dec_step = dec_bus[STEP_W-1:0];

   // Round-trip check: the encoder's output, read back by a separate decoder, must give the input again
   logic              chk_sign;
   logic [SEG_W-1:0]  chk_seg;
   logic [STEP_W-1:0] chk_step;

   lc_decode #(.SEG_W(SEG_W), .STEP_W(STEP_W)) u_chk_dec (
      .law       (law_eff),
      .line_char (enc_raw),
      .sign      (chk_sign),
      .seg       (chk_seg),
      .step      (chk_step)
   );

   always_comb begin
      if (rst_n) begin
         assert_round_trip_R5 : assert ({chk_sign, chk_seg, chk_step} ==
                                        {enc_sign, enc_seg, enc_step})
            else $error("round trip mismatch");
      end
   end

   generate
      if (OUT_REG) begin : g_reg_checks
         assert_valid_rise_R6 : assert property (@(posedge clk) disable iff (!rst_n)
            enc_valid_in |=> enc_valid_out);
         assert_valid_fall_R6 : assert property (@(posedge clk) disable iff (!rst_n)
            !dec_valid_in |=> !dec_valid_out);
         assert_hold_enc_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            !enc_valid_in |=> $stable(enc_char));
         assert_hold_dec_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            !dec_valid_in |=> $stable(dec_bus));
         assert_sign_pass_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            dec_valid_in |=> (dec_sign == $past(dec_char[CHAR_W-1])));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               assert_reset_idle_R8 : assert (!enc_valid_out && !dec_valid_out &&
                                              enc_char == '0 && dec_bus == '0)
                  else $error("outputs not idle in reset");
            end
         end
      end
   endgenerate
endmodule

// File: tb/test_pcm_law_coder.sv
module test_pcm_law_coder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       law_sel = 1'b0;
   logic       enc_valid_in = 1'b0;
   logic       enc_sign = 1'b0;
   logic [2:0] enc_seg = '0;
   logic [3:0] enc_step = '0;
   logic       enc_valid_out;
   logic [7:0] enc_char;
   logic       dec_valid_in = 1'b0;
   logic [7:0] dec_char = '0;
   logic       dec_valid_out;
   logic       dec_sign;
   logic [2:0] dec_seg;
   logic [3:0] dec_step;

   always #2 clk = ~clk;   // 250 MHz

   pcm_law_coder i_pcm_law_coder (
      .clk, .rst_n, .law_sel,
      .enc_valid_in, .enc_sign, .enc_seg, .enc_step,
      .enc_valid_out, .enc_char,
      .dec_valid_in, .dec_char,
      .dec_valid_out, .dec_sign, .dec_seg, .dec_step
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R8";

   // Behavioural model state: what the outputs must show after the next edge
   logic       exp_ev = 1'b0;
   logic [7:0] exp_ec = '0;
   logic       exp_dv = 1'b0;
   logic [7:0] exp_dc = '0;

   function automatic logic [7:0] ref_enc(input logic law, input logic s, input int mag);
      logic [6:0] m;
      if (!law) begin
         m = 7'(127 - mag);
      end else begin
         m = 7'(mag);
         for (int b = 0; b < 7; b += 2) m[b] = ~m[b];
      end
      return {s, m};
   endfunction

   function automatic logic [7:0] ref_dec(input logic law, input logic [7:0] c);
      logic [6:0] m;
      if (!law) begin
         m = 7'(127 - int'(c[6:0]));
      end else begin
         m = c[6:0];
         for (int b = 0; b < 7; b += 2) m[b] = ~m[b];
      end
      return {c[7], m};
   endfunction

   task automatic check(input string what, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   // Wait for the falling edge and compare against the model
   task automatic tick();
      @(negedge clk);
      check("enc", {enc_valid_out, enc_char}, {exp_ev, exp_ec});
      check("dec", {dec_valid_out, dec_sign, dec_seg, dec_step}, {exp_dv, exp_dc});
   endtask

   task automatic drive(input logic ve, input logic [7:0] code,
                        input logic vd, input logic [7:0] ch);
      enc_valid_in = ve;
      enc_sign     = code[7];
      enc_seg      = code[6:4];
      enc_step     = code[3:0];
      dec_valid_in = vd;
      dec_char     = ch;
      if (rst_n) begin
         exp_ev = ve;
         if (ve) exp_ec = ref_enc(law_sel, code[7], int'(code[6:0]));
         exp_dv = vd;
         if (vd) exp_dc = ref_dec(law_sel, ch);
      end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R8: reset, with active stimulus that must be ignored
      cur_req = "R8";
      for (int i = 0; i < 4; i++) begin
         tick();
         drive(1'b1, 8'(i * 37), 1'b1, 8'(i * 91));
      end
      tick();
      drive(1'b0, 8'h00, 1'b0, 8'h00);
      rst_n = 1'b1;
      tick();

      // R3: mu-law end points
      cur_req = "R3";
      law_sel = 1'b0;
      drive(1'b1, 8'hFF, 1'b0, 8'h00); tick(); check("mu +fs", {1'b0, enc_char}, 9'h080);
      drive(1'b1, 8'h7F, 1'b0, 8'h00); tick(); check("mu -fs", {1'b0, enc_char}, 9'h000);
      drive(1'b1, 8'h80, 1'b0, 8'h00); tick(); check("mu +0",  {1'b0, enc_char}, 9'h0FF);
      drive(1'b1, 8'h00, 1'b0, 8'h00); tick(); check("mu -0",  {1'b0, enc_char}, 9'h07F);

      // R4: A-law end points
      cur_req = "R4";
      drive(1'b0, 8'h00, 1'b0, 8'h00); tick();
      law_sel = 1'b1;
      drive(1'b1, 8'hFF, 1'b0, 8'h00); tick(); check("A +fs", {1'b0, enc_char}, 9'h0AA);
      drive(1'b1, 8'h7F, 1'b0, 8'h00); tick(); check("A -fs", {1'b0, enc_char}, 9'h02A);
      drive(1'b1, 8'h80, 1'b0, 8'h00); tick(); check("A +0",  {1'b0, enc_char}, 9'h0D5);
      drive(1'b1, 8'h00, 1'b0, 8'h00); tick(); check("A -0",  {1'b0, enc_char}, 9'h055);

      // R1 and R2: full sweeps in both directions; R9: sign of every decoded character
      for (int law = 0; law < 2; law++) begin
         drive(1'b0, 8'h00, 1'b0, 8'h00); tick();
         law_sel = law[0];
         cur_req = law ? "R2" : "R1";
         for (int v = 0; v < 256; v++) begin
            drive(1'b1, 8'(v), 1'b1, 8'(255 - v));
            tick();
            cur_req = "R9";
            check("sign", {8'h00, dec_sign}, {8'h00, 1'(((255 - v) >> 7) & 1)});
            cur_req = law ? "R2" : "R1";
         end
      end

      // R6: single pulses and gaps
      cur_req = "R6";
      law_sel = 1'b0;
      drive(1'b1, 8'h3C, 1'b0, 8'h11); tick();
      drive(1'b0, 8'h3C, 1'b1, 8'h22); tick();
      drive(1'b0, 8'h00, 1'b0, 8'h00); tick();
      drive(1'b1, 8'hC3, 1'b1, 8'h99); tick();
      drive(1'b0, 8'h00, 1'b0, 8'h00); tick();

      // R7: data changes with valid low must not reach the outputs
      cur_req = "R7";
      for (int i = 0; i < 20; i++) begin
         drive(1'b0, 8'(i * 13 + 5), 1'b0, 8'(i * 29 + 3));
         tick();
      end
      law_sel = 1'b1;
      for (int i = 0; i < 6; i++) begin
         drive(1'b0, 8'(i * 41), 1'b0, 8'(i * 7));
         tick();
      end

      // R5: decode every character, feed the result back into the encoder
      cur_req = "R5";
      for (int law = 0; law < 2; law++) begin
         drive(1'b0, 8'h00, 1'b0, 8'h00); tick();
         law_sel = law[0];
         for (int i = 0; i < 258; i++) begin
            if (i >= 2) check("round trip", {1'b0, enc_char}, {1'b0, 8'(i - 2)});
            drive(i >= 1, {dec_sign, dec_seg, dec_step}, i < 256, 8'(i));
            tick();
         end
      end

      drive(1'b0, 8'h00, 1'b0, 8'h00);
      tick();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule